// File: doc/BRIEF.md
# SD Low-Voltage Signaling Initiation Sequencer

This block runs, in hardware, the pin-level handshake that finds out whether an SD card can work with 1.8 V signaling from power-up. A single start strobe launches it. The sequencer first checks that the host can do low-voltage signaling. It then holds CMD, DAT3, DAT1 and DAT0 low, switches the DAT2 resistor network to pull-down, waits for the internal clock to report stable, and emits exactly one SD clock pulse. The width of that pulse is set by a latched count and a timebase select.

After the pulse, a long settle window gives the card time to answer by raising DAT2. The DAT2 level, taken through a synchronizer, decides the outcome. On a pass, the block releases the lines to their pull-ups and enables the continuous SD clock. On a fail, it raises a request to cut card power.

The start strobe is a plain control pin with no back-pressure. A strobe that arrives while the block is busy is dropped. All outputs are control levels that come straight from registered state. The settle length is a parameter so that simulation can shorten it.

Top module: `lvs_init_seq`

## Requirements
- R1: If `cap_lvs_i` is low when a start is accepted, the block stays idle: `busy_o`, `lines_low_o`, `dat2_pd_o` and `sdclk_o` stay 0. `done_o` pulses in the next cycle with `result_o`=0 and `pwr_off_o`=0.
- R2: `pulse_cnt_i` and `tick_sel_i` are latched when a start is accepted. The pulse on `sdclk_o` lasts max(cnt,1) × 2^(4×sel) clock cycles, where sel 0/1/2/3 gives a tick of 1/16/256/4096 cycles.
- R3: The pulse starts in the cycle after the first clock edge at which `clk_stable_i` is seen high in the wait state. While `clk_stable_i` stays low, `sdclk_o` stays 0.
- R4: From an accepted start with capability until `done_o`, `busy_o`, `lines_low_o` and `dat2_pd_o` are all 1.
- R5: One handshake produces exactly one high interval on `sdclk_o`. `sdclk_o` is never high while `busy_o` is low.
- R6: After the pulse ends, the block waits SETTLE_CYC cycles and then evaluates. `done_o` rises SETTLE_CYC cycles after `sdclk_o` falls. The evaluated DAT2 value is `dat2_i` as seen two clock edges before the evaluating edge (two-flop synchronizer).
- R7: A high DAT2 at evaluation sets `result_o`=1 and `sdclk_en_o`=1, and drives `lines_low_o` and `dat2_pd_o` to 0 (pull-up). `pwr_off_o` stays 0.
- R8: A low DAT2 at evaluation sets `result_o`=0 and `pwr_off_o`=1 and keeps `dat2_pd_o`=1. `lines_low_o` and `sdclk_en_o` are 0.
- R9: `done_o` is high for exactly one cycle, and it is the same cycle in which `busy_o` first reads 0.
- R10: `start_i` has no effect while `busy_o` is 1. A running handshake keeps its latched pulse width and its timing.
- R11: `result_o`, `pwr_off_o` and `sdclk_en_o` hold their values until the next accepted start, which clears them.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| cap_lvs_i | input | 1 | Host low-voltage signaling capability |
| clk_stable_i | input | 1 | Internal SD clock reported stable |
| pulse_cnt_i | input | CNT_W | Pulse length in ticks (0 means 1) |
| tick_sel_i | input | 2 | Tick timebase select |
| dat2_i | input | 1 | DAT2 level from the card |
| busy_o | output | 1 | Handshake in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | 1 = card answered low-voltage capable |
| pwr_off_o | output | 1 | Request to remove card power |
| sdclk_o | output | 1 | Handshake clock pulse for the SD clock pin |
| sdclk_en_o | output | 1 | Continuous SD clock enable after a pass |
| lines_low_o | output | 1 | Drive CMD, DAT3, DAT1, DAT0 low |
| dat2_pd_o | output | 1 | DAT2 resistor select: 1 pull-down, 0 pull-up |

## Verification
A state register that sits in the wrong place shows at once in `busy_o`, `lines_low_o` and `sdclk_o`, because these outputs decode the state with no further delay. A mismatch with the per-clock model is therefore visible within one cycle. A divider or tick counter that runs off count moves the falling edge of `sdclk_o` and every later `done_o`, so the error appears at the first pulse end. A fault in the synchronizer or the evaluation logic can hide until the evaluating edge. To expose it, DAT2 is changed close to that edge and both outcomes are run.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WCLK   = 2'd1,
    ST_PULSE  = 2'd2,
    ST_SETTLE = 2'd3
  } lvs_state_t;
endpackage

// File: rtl/lvs_sync.sv
module lvs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvs_pulse_timer.sv
module lvs_pulse_timer #(
  parameter int CNT_W = 8,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       tsel_i,
  output logic             last_o
);
  localparam int DIV_W = STEP * 3;

  logic [DIV_W-1:0] div_q, div_max;
  logic [CNT_W-1:0] tick_q, tick_last;
  logic             div_hit;

  // Tick period is 2^(STEP*tsel) system cycles.
  always_comb begin
    div_max = '0;
    for (int i = 0; i < DIV_W; i++)
      if (i < STEP * int'(tsel_i)) div_max[i] = 1'b1;
  end

  assign tick_last = (cnt_i == '0) ? '0 : cnt_i - CNT_W'(1);
  assign div_hit   = (div_q == div_max);
  assign last_o    = run_i && div_hit && (tick_q == tick_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= '0;
    end else if (!run_i) begin
      div_q  <= '0;
      tick_q <= '0;
    end else if (div_hit) begin
      div_q  <= '0;
      tick_q <= tick_q + CNT_W'(1);
    end else begin
      div_q  <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/lvs_settle_timer.sv
module lvs_settle_timer #(
  parameter int SETTLE_CYC = 501000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/lvs_init_seq.sv
module lvs_init_seq
  import lvs_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int STEP       = 4,
  parameter int SETTLE_CYC = 501000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cap_lvs_i,
  input  logic             clk_stable_i,
  input  logic [CNT_W-1:0] pulse_cnt_i,
  input  logic [1:0]       tick_sel_i,
  input  logic             dat2_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             result_o,
  output logic             pwr_off_o,
  output logic             sdclk_o,
  output logic             sdclk_en_o,
  output logic             lines_low_o,
  output logic             dat2_pd_o
);
  lvs_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       tsel_q;
  logic             dat2_s, pulse_last, settle_last;
  logic             done_q, res_q, pwr_q, en_q;

  lvs_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(dat2_i), .q_o(dat2_s)
  );

  lvs_pulse_timer #(.CNT_W(CNT_W), .STEP(STEP)) u_pulse (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_PULSE),
    .cnt_i(cnt_q), .tsel_i(tsel_q), .last_o(pulse_last)
  );

  lvs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_SETTLE),
    .last_o(settle_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tsel_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= 1'b0;
      pwr_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          res_q  <= 1'b0;
          pwr_q  <= 1'b0;
          en_q   <= 1'b0;
          cnt_q  <= pulse_cnt_i;
          tsel_q <= tick_sel_i;
          if (cap_lvs_i) state_q <= ST_WCLK;
          else           done_q  <= 1'b1;
        end
        ST_WCLK:   if (clk_stable_i) state_q <= ST_PULSE;
        ST_PULSE:  if (pulse_last)   state_q <= ST_SETTLE;
        ST_SETTLE: if (settle_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          res_q   <= dat2_s;
          pwr_q   <= !dat2_s;
          en_q    <= dat2_s;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign pwr_off_o   = pwr_q;
  assign sdclk_o     = (state_q == ST_PULSE);
  assign sdclk_en_o  = en_q;
  assign lines_low_o = busy_o;
  assign dat2_pd_o   = busy_o || pwr_q;
endmodule

// File: rtl/lvs_init_seq_chk.sv
module lvs_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic cap_lvs_i,
  input logic clk_stable_i,
  input logic busy_o,
  input logic done_o,
  input logic result_o,
  input logic pwr_off_o,
  input logic sdclk_o,
  input logic sdclk_en_o,
  input logic lines_low_o,
  input logic dat2_pd_o
);
  logic sd_prev;
  logic [1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_prev <= 1'b0;
      rises   <= '0;
    end else begin
      sd_prev <= sdclk_o;
      if (!busy_o) rises <= '0;
      else if (sdclk_o && !sd_prev && rises != 2'd3) rises <= rises + 2'd1;
    end
  end

  AST_BUSY_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cap_lvs_i)); // R1
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(busy_o)) |-> (!result_o && !pwr_off_o && !dat2_pd_o)); // R1
  AST_PULSE_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdclk_o) |-> $past(clk_stable_i)); // R3
  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (lines_low_o && dat2_pd_o)); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sdclk_o && !sd_prev) |-> (rises == 2'd0)); // R5
  AST_NO_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sdclk_o); // R5
  AST_PASS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o) |-> (sdclk_en_o && !pwr_off_o && !dat2_pd_o && !lines_low_o)); // R7
  AST_FAIL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_o |-> (!result_o && !sdclk_en_o && dat2_pd_o)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> ($stable(result_o) && $stable(pwr_off_o) && $stable(sdclk_en_o))); // R11
endmodule

bind lvs_init_seq lvs_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cap_lvs_i(cap_lvs_i),
  .clk_stable_i(clk_stable_i), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .pwr_off_o(pwr_off_o), .sdclk_o(sdclk_o),
  .sdclk_en_o(sdclk_en_o), .lines_low_o(lines_low_o), .dat2_pd_o(dat2_pd_o)
);

// File: tb/lvs_init_seq_tb.sv
`timescale 1ns/1ps
module lvs_init_seq_tb;
  localparam int CNT_W  = 8;
  localparam int SETTLE = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, cap_lvs_i = 0, clk_stable_i = 0, dat2_i = 0;
  logic [CNT_W-1:0] pulse_cnt_i = '0;
  logic [1:0] tick_sel_i = '0;
  logic busy_o, done_o, result_o, pwr_off_o, sdclk_o, sdclk_en_o, lines_low_o, dat2_pd_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  lvs_init_seq #(.CNT_W(CNT_W), .STEP(4), .SETTLE_CYC(SETTLE)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int  m_phase = 0, m_k = 0, m_w = 0;
  bit  m_done = 0, m_res = 0, m_pwr = 0, m_en = 0;
  bit  hist[$] = '{1'b0, 1'b0};

  always @(posedge clk) begin
    bit smp;
    if (!rst_n) begin
      m_phase = 0; m_k = 0; m_done = 0; m_res = 0; m_pwr = 0; m_en = 0;
      hist = '{1'b0, 1'b0};
    end else begin
      smp = hist[1];
      hist.push_front(dat2_i);
      void'(hist.pop_back());
      m_done = 0;
      case (m_phase)
        0: if (start_i) begin
          m_res = 0; m_pwr = 0; m_en = 0;
          m_w = ((pulse_cnt_i == 0) ? 1 : int'(pulse_cnt_i)) << (4 * int'(tick_sel_i));
          if (cap_lvs_i) m_phase = 1; else m_done = 1;
        end
        1: if (clk_stable_i) begin m_phase = 2; m_k = 0; end
        2: begin m_k++; if (m_k == m_w) begin m_phase = 3; m_k = 0; end end
        default: begin
          m_k++;
          if (m_k == SETTLE) begin
            m_phase = 0; m_done = 1; m_res = smp; m_pwr = !smp; m_en = smp;
          end
        end
      endcase
    end
  end

  // Per-cycle comparison, away from the active edge.
  int hi_cnt = 0, last_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 busy_o",      busy_o,      m_phase != 0);
      chk("R4 lines_low_o", lines_low_o, m_phase != 0);
      chk("R8 dat2_pd_o",   dat2_pd_o,   (m_phase != 0) || m_pwr);
      chk("R5 sdclk_o",     sdclk_o,     m_phase == 2);
      chk("R9 done_o",      done_o,      m_done);
      chk("R7 result_o",    result_o,    m_res);
      chk("R8 pwr_off_o",   pwr_off_o,   m_pwr);
      chk("R11 sdclk_en_o", sdclk_en_o,  m_en);
      if (sdclk_o) hi_cnt++;
      if (done_o) begin last_w = hi_cnt; hi_cnt = 0; end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
    @(negedge clk);
  endtask

  task automatic run(int cnt, int sel, int stab_delay, bit d2, bit extra_start);
    @(negedge clk);
    pulse_cnt_i = CNT_W'(cnt); tick_sel_i = 2'(sel);
    cap_lvs_i = 1; clk_stable_i = (stab_delay == 0); dat2_i = d2; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (stab_delay > 0) begin
      repeat (stab_delay) begin
        @(negedge clk);
        chk("R3 no pulse before stable", sdclk_o, 0);
      end
      clk_stable_i = 1;
    end
    if (extra_start) begin // R10: new start with other settings while busy
      pulse_cnt_i = 8'd9; tick_sel_i = 2'd1; start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    wait_done();
    chk("R2 pulse width", last_w, ((cnt == 0) ? 1 : cnt) << (4 * sel));
    chk(d2 ? "R7 pass result" : "R8 fail result", result_o, d2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy_o", busy_o, 0);
    chk("R12 reset dat2_pd_o", dat2_pd_o, 0);
    chk("R12 reset done_o", done_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1: no capability -> abort without touching the bus
    cap_lvs_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R1 abort done_o", done_o, 1);
    chk("R1 abort lines_low_o", lines_low_o, 0);
    chk("R1 abort pwr_off_o", pwr_off_o, 0);
    repeat (3) @(negedge clk);

    run(3, 0, 0, 1'b1, 1'b0);          // R7 pass, short pulse
    repeat (5) @(negedge clk);
    chk("R11 hold sdclk_en_o", sdclk_en_o, 1);
    run(0, 1, 0, 1'b0, 1'b0);          // R8 fail, zero count = one tick
    chk("R8 power-off request", pwr_off_o, 1);
    run(5, 0, 12, 1'b1, 1'b1);         // R3 late stable, R10 ignored start
    run(1, 2, 0, 1'b0, 1'b0);          // R2 256-cycle tick
    run(1, 3, 0, 1'b1, 1'b0);          // R2 4096-cycle tick

    // R6: DAT2 rises late in the settle window; the model decides the cut-off
    @(negedge clk);
    pulse_cnt_i = 8'd2; tick_sel_i = 0; cap_lvs_i = 1; clk_stable_i = 1; dat2_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (1 + 2 + SETTLE - 2) @(negedge clk);
    dat2_i = 1;
    wait_done();
    chk("R6 synchronizer delay keeps fail", result_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule